// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers seven reset requests into one system reset that is released on a clock edge. The requests are:

- power-on or supply failure;
- the external active-low reset pin;
- the external conversion-start pin;
- a software strobe;
- a comparator trip;
- a missing-clock pulse;
- a watchdog expiry.

The comparator, conversion-start, missing-clock and watchdog requests each pass through their own software enable. Requests arriving from outside the clock domain go through a two-flop synchronizer. Every reset lasts at least a fixed minimum number of cycles.

A supply failure, or a software write that asks for a power-on style reset, reloads a programmable supply timeout counter. While that counter runs, the block pulls the shared reset pin low, so the rest of the board is reset as well. The block keeps its own pin sense from treating that self-driven low level as a new pin reset.

A cause register records which source started the most recent reset. The block also presents the values that the rest of the chip loads on reset:

- port latches all ones;
- watchdog enabled, at its longest interval;
- internal oscillator selected as the clock;
- program-counter vector zero.

Top module: `sysrst_hub`

## Requirements
- R1: Any enabled request asserts `sys_rst`. The asynchronous requests are `rst_pin_n` low, `cnvst`, `cmp_trip`, `mcd_pulse` and `wdt_expire`. The synchronous request is `sw_strobe`, sampled at a clock edge. A request active for N sampled cycles holds `sys_rst` high for N+3 cycles.
- R2: `src_en` bit 0 gates conversion-start, bit 1 the comparator, bit 2 missing-clock and bit 3 the watchdog. A request from a source whose bit is 0 changes neither `sys_rst` nor `cause`.
- R3: `sys_rst` stays high for at least MIN_HOLD (4) cycles. It falls on a clock edge only after MIN_HOLD edges in a row with no request and no supply timeout running.
- R4: `supply_fail` high asserts `sys_rst` and `pin_drive_low` at once. After it falls, `pin_drive_low` stays high for TMO_CYCLES more edges, and `sys_rst` for TMO_CYCLES+MIN_HOLD more edges.
- R5: A one-cycle `sw_por` reloads the supply timeout. From the next cycle, `pin_drive_low` is high for TMO_CYCLES cycles and `sys_rst` for TMO_CYCLES+MIN_HOLD cycles.
- R6: `cause` is one-hot, with these bit positions:

  | Bit | Source |
  |---|---|
  | 0 | power-on |
  | 1 | pin |
  | 2 | conversion-start |
  | 3 | software strobe |
  | 4 | comparator |
  | 5 | missing-clock |
  | 6 | watchdog |

  Only the source that starts a reset from the idle state sets its bit. Requests that arrive while reset is already active extend the reset but leave `cause` unchanged until the next reset.
- R7: When several sources start a reset on the same edge, the lowest bit index is recorded.
- R8: While `pin_drive_low` is high, and for two cycles after it falls, a low level on `rst_pin_n` is not treated as a pin request. A power-on style reset therefore keeps its power-on cause and is not lengthened.
- R9: The reset-default outputs have these fixed values:

  | Output | Value |
  |---|---|
  | `port_init` | all ones (0xFF) |
  | `wdt_en_init` | 1 |
  | `wdt_sel_init` | all ones (longest interval) |
  | `clk_sel_init` | 0 (internal oscillator) |
  | `pc_init` | 0x0000 |

- R10: A supply failure or `sw_por` sets `cause` to the power-on value 7'b0000001 and clears every other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_fail | input | 1 | Supply monitor fail/power-on, active high, asynchronous |
| rst_pin_n | input | 1 | Sensed level of the shared reset pin, active low |
| cnvst | input | 1 | Conversion-start pin request |
| cmp_trip | input | 1 | Comparator trip request |
| mcd_pulse | input | 1 | Missing-clock detector one-shot |
| wdt_expire | input | 1 | Watchdog timeout request |
| sw_strobe | input | 1 | Software reset strobe, synchronous |
| sw_por | input | 1 | Software power-on reset request, synchronous |
| src_en | input | 4 | Enables: cnvst, cmp, mcd, wdt |
| sys_rst | output | 1 | System reset, active high |
| pin_drive_low | output | 1 | Pull the shared reset pin low |
| cause | output | 7 | One-hot last reset cause |
| port_init | output | 8 | Port latch reset value |
| wdt_en_init | output | 1 | Watchdog enable reset value |
| wdt_sel_init | output | 3 | Watchdog interval reset value |
| clk_sel_init | output | 1 | Clock select reset value (0 = internal) |
| pc_init | output | 16 | Reset vector |

## Verification
The bench measures exact reset lengths for each source and for several pulse widths. A missing synchronizer stage or a wrong hold count would shift every length by a cycle.

It raises a second request while a reset is already running. A design that re-captured the cause at that point would report the later source instead of the first.

It starts two enabled sources on the same edge and pulses every source while its enable bit is clear. Wrong priority would record the higher bit, and a leaky enable would produce a stray reset.

A software power-on reset is checked for the drive length and the full reset length. A design that failed to mask its own pin drive would lengthen that reset and report a pin cause.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int NSRC    = 7;
  localparam int SRC_POR = 0;
  localparam int SRC_PIN = 1;
  localparam int SRC_CNV = 2;
  localparam int SRC_SW  = 3;
  localparam int SRC_CMP = 4;
  localparam int SRC_MCD = 5;
  localparam int SRC_WDT = 6;

  typedef logic [NSRC-1:0] src_vec_t;

  localparam src_vec_t POR_ONLY = src_vec_t'(1) << SRC_POR;

  // Lowest set index wins; result is one-hot or zero.
  function automatic src_vec_t first_src(src_vec_t v);
    src_vec_t r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = src_vec_t'(1) << i;
    end
    return r;
  endfunction

  // Down-counter step with reload; saturates at zero.
  function automatic logic [31:0] count_step(logic load, logic [31:0] cur,
                                             logic [31:0] reload);
    if (load) return reload;
    if (cur != 32'd0) return cur - 32'd1;
    return 32'd0;
  endfunction
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain[0] <= '0;
        else      chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain[g] <= '0;
        else      chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sysrst_supply_timer.sv
module sysrst_supply_timer
  import sysrst_pkg::*;
#(
  parameter int TMO_CYCLES  = 100,
  parameter int MASK_STAGES = 2
) (
  input  logic clk,
  input  logic supply_fail,
  input  logic sw_por,
  output logic tmo_active,
  output logic pin_mask
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TMO_CYCLES);

  logic [CNT_W-1:0]       cnt;
  logic [MASK_STAGES-1:0] drv_hist;

  always_ff @(posedge clk or posedge supply_fail) begin
    if (supply_fail) cnt <= RELOAD;
    else cnt <= CNT_W'(count_step(sw_por, 32'(cnt), 32'(TMO_CYCLES)));
  end

  assign tmo_active = (cnt != '0);

  // Drive history covers the pin synchronizer latency after drive release.
  always_ff @(posedge clk or posedge supply_fail) begin
    if (supply_fail) drv_hist <= '1;
    else             drv_hist <= {drv_hist[MASK_STAGES-2:0], tmo_active};
  end

  assign pin_mask = tmo_active | (|drv_hist);

  assert_swpor_drive_R5: assert property (@(posedge clk) disable iff (supply_fail)
    sw_por |=> tmo_active);
endmodule

// File: rtl/sysrst_hold.sv
module sysrst_hold
  import sysrst_pkg::*;
#(
  parameter int MIN_HOLD = 4
) (
  input  logic clk,
  input  logic supply_fail,
  input  logic tmo_active,
  input  logic req_any,
  output logic hold_active
);
  localparam int HOLD_W = $clog2(MIN_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_HOLD);

  logic [HOLD_W-1:0] cnt;
  logic              reload;

  assign reload = tmo_active | req_any;

  always_ff @(posedge clk or posedge supply_fail) begin
    if (supply_fail) cnt <= HOLD_LOAD;
    else cnt <= HOLD_W'(count_step(reload, 32'(cnt), 32'(MIN_HOLD)));
  end

  assign hold_active = (cnt != '0);

  assert_release_quiet_R3: assert property (@(posedge clk) disable iff (supply_fail)
    $fell(hold_active) |-> (!$past(req_any) && !$past(tmo_active)));
endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
  import sysrst_pkg::*;
(
  input  logic     clk,
  input  logic     supply_fail,
  input  logic     sw_por,
  input  logic     entry,
  input  logic     in_rst,
  input  src_vec_t req_vec,
  input  logic     cmp_en,
  output src_vec_t cause
);
  always_ff @(posedge clk or posedge supply_fail) begin
    if (supply_fail)  cause <= POR_ONLY;
    else if (sw_por)  cause <= POR_ONLY;
    else if (entry)   cause <= first_src(req_vec);
  end

  assert_cause_stable_R6: assert property (@(posedge clk) disable iff (supply_fail)
    ($past(in_rst) && !$past(sw_por)) |-> $stable(cause));

  assert_cmp_gate_R2: assert property (@(posedge clk) disable iff (supply_fail)
    $rose(cause[SRC_CMP]) |-> $past(cmp_en));
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
  import sysrst_pkg::*;
#(
  parameter int TMO_CYCLES  = 100,
  parameter int MIN_HOLD    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PORT_W      = 8,
  parameter int WDT_SEL_W   = 3,
  parameter int PC_W        = 16
) (
  input  logic                 clk,
  input  logic                 supply_fail,
  input  logic                 rst_pin_n,
  input  logic                 cnvst,
  input  logic                 cmp_trip,
  input  logic                 mcd_pulse,
  input  logic                 wdt_expire,
  input  logic                 sw_strobe,
  input  logic                 sw_por,
  input  logic [3:0]           src_en,
  output logic                 sys_rst,
  output logic                 pin_drive_low,
  output logic [NSRC-1:0]      cause,
  output logic [PORT_W-1:0]    port_init,
  output logic                 wdt_en_init,
  output logic [WDT_SEL_W-1:0] wdt_sel_init,
  output logic                 clk_sel_init,
  output logic [PC_W-1:0]      pc_init
);
  localparam int NASYNC = 5;

  logic [NASYNC-1:0] async_raw;
  logic [NASYNC-1:0] async_s;
  logic              tmo_active;
  logic              pin_mask;
  logic              hold_active;
  src_vec_t          req_vec;
  logic              req_any;
  logic              entry;
  src_vec_t          cause_q;

  // Synchronizer lanes: 0 pin low, 1 cnvst, 2 comparator, 3 missing clock, 4 watchdog.
  assign async_raw = {wdt_expire, mcd_pulse, cmp_trip, cnvst, ~rst_pin_n};

  sysrst_sync #(.WIDTH(NASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .arst (supply_fail),
    .d    (async_raw),
    .q    (async_s)
  );

  sysrst_supply_timer #(.TMO_CYCLES(TMO_CYCLES), .MASK_STAGES(SYNC_STAGES)) u_timer (
    .clk         (clk),
    .supply_fail (supply_fail),
    .sw_por      (sw_por),
    .tmo_active  (tmo_active),
    .pin_mask    (pin_mask)
  );

  always_comb begin
    req_vec          = '0;
    req_vec[SRC_PIN] = async_s[0] & ~pin_mask;
    req_vec[SRC_CNV] = async_s[1] & src_en[0];
    req_vec[SRC_SW]  = sw_strobe;
    req_vec[SRC_CMP] = async_s[2] & src_en[1];
    req_vec[SRC_MCD] = async_s[3] & src_en[2];
    req_vec[SRC_WDT] = async_s[4] & src_en[3];
  end

  assign req_any = |req_vec;

  sysrst_hold #(.MIN_HOLD(MIN_HOLD)) u_hold (
    .clk         (clk),
    .supply_fail (supply_fail),
    .tmo_active  (tmo_active),
    .req_any     (req_any),
    .hold_active (hold_active)
  );

  assign sys_rst       = tmo_active | hold_active;
  assign pin_drive_low = tmo_active;
  assign entry         = req_any & ~sys_rst;

  sysrst_cause u_cause (
    .clk         (clk),
    .supply_fail (supply_fail),
    .sw_por      (sw_por),
    .entry       (entry),
    .in_rst      (sys_rst),
    .req_vec     (req_vec),
    .cmp_en      (src_en[1]),
    .cause       (cause_q)
  );

  assign cause = cause_q;

  // Reset-default values (R9).
  assign port_init    = '1;
  assign wdt_en_init  = 1'b1;
  assign wdt_sel_init = '1;
  assign clk_sel_init = 1'b0;
  assign pc_init      = '0;

  assert_drive_then_hold_R4: assert property (@(posedge clk) disable iff (supply_fail)
    $fell(pin_drive_low) |-> sys_rst);

  assert_single_cause_R6: assert property (@(posedge clk) disable iff (supply_fail)
    ($rose(sys_rst) && !pin_drive_low) |-> ($countones(cause) == 1));
endmodule

// File: tb/sysrst_hub_bench.sv
module sysrst_hub_bench;
  localparam int TMO  = 100;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic supply_fail = 1'b0;
  logic ext_pull = 1'b0;
  logic cnvst = 1'b0, cmp_trip = 1'b0, mcd_pulse = 1'b0, wdt_expire = 1'b0;
  logic sw_strobe = 1'b0, sw_por = 1'b0;
  logic [3:0] src_en = 4'hF;
  logic rst_pin_n;
  logic sys_rst, pin_drive_low, wdt_en_init, clk_sel_init;
  logic [6:0]  cause;
  logic [7:0]  port_init;
  logic [2:0]  wdt_sel_init;
  logic [15:0] pc_init;

  // Open-drain pin: low if either side pulls.
  assign rst_pin_n = ~(pin_drive_low | ext_pull);

  sysrst_hub #(.TMO_CYCLES(TMO), .MIN_HOLD(HOLD)) u_sysrst_hub (
    .clk(clk), .supply_fail(supply_fail), .rst_pin_n(rst_pin_n), .cnvst(cnvst),
    .cmp_trip(cmp_trip), .mcd_pulse(mcd_pulse), .wdt_expire(wdt_expire),
    .sw_strobe(sw_strobe), .sw_por(sw_por), .src_en(src_en), .sys_rst(sys_rst),
    .pin_drive_low(pin_drive_low), .cause(cause), .port_init(port_init),
    .wdt_en_init(wdt_en_init), .wdt_sel_init(wdt_sel_init),
    .clk_sel_init(clk_sel_init), .pc_init(pc_init)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard queues: expected cause, reset length, drive length, tag.
  logic [6:0] qf[$];
  int         ql[$];
  int         qd[$];
  string      qt[$];
  bit         mon_on = 0;

  task automatic expect_evt(string tag, logic [6:0] f, int len, int dlen);
    qf.push_back(f); ql.push_back(len); qd.push_back(dlen); qt.push_back(tag);
  endtask

  int  m_len = 0, m_dlen = 0;
  bit  m_prev = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (sys_rst) begin
        m_len++;
        if (pin_drive_low) m_dlen++;
      end
      if (m_prev && !sys_rst) begin
        if (qf.size() == 0) begin
          chk("R2 unexpected reset", 32'd1, 32'd0);
        end else begin
          string t;
          t = qt.pop_front();
          chk({t, " cause"}, 32'(cause), 32'(qf.pop_front()));
          chk({t, " reset length"}, 32'(m_len), 32'(ql.pop_front()));
          chk({t, " drive length"}, 32'(m_dlen), 32'(qd.pop_front()));
        end
        m_len = 0; m_dlen = 0;
      end
      m_prev = sys_rst;
    end
  end

  task automatic wait_idle();
    tick(2);
    while (sys_rst) tick(1);
    tick(3);
  endtask

  // which: 0 pin, 1 cnvst, 2 cmp, 3 mcd, 4 wdt, 5 sw_strobe
  task automatic set_src(int which, logic v);
    case (which)
      0: ext_pull   = v;
      1: cnvst      = v;
      2: cmp_trip   = v;
      3: mcd_pulse  = v;
      4: wdt_expire = v;
      default: sw_strobe = v;
    endcase
  endtask

  task automatic pulse(int which, int n);
    set_src(which, 1'b1);
    tick(n);
    set_src(which, 1'b0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int c_rst, c_drv;
    #1 supply_fail = 1'b1;
    tick(3);
    chk("R4 reset during supply fail", 32'(sys_rst), 32'd1);
    chk("R4 drive during supply fail", 32'(pin_drive_low), 32'd1);
    chk("R10 power-on cause", 32'(cause), 32'h01);
    chk("R9 port latch default", 32'(port_init), 32'hFF);
    chk("R9 watchdog enable default", 32'(wdt_en_init), 32'd1);
    chk("R9 watchdog interval default", 32'(wdt_sel_init), 32'h7);
    chk("R9 clock select default", 32'(clk_sel_init), 32'd0);
    chk("R9 reset vector", 32'(pc_init), 32'd0);
    supply_fail = 1'b0;
    c_rst = 0; c_drv = 0;
    do begin
      tick(1);
      if (sys_rst) c_rst++;
      if (pin_drive_low) c_drv++;
    end while (sys_rst);
    chk("R4 reset after supply release", 32'(c_rst), 32'(TMO + HOLD - 1));
    chk("R4 drive after supply release", 32'(c_drv), 32'(TMO - 1));
    chk("R8 power-on cause kept after drive", 32'(cause), 32'h01);
    tick(3);
    mon_on = 1;

    expect_evt("R1 R3 sw strobe", 7'b0001000, 4, 0);
    pulse(5, 1); wait_idle();
    expect_evt("R1 pin 3 cycles", 7'b0000010, 6, 0);
    pulse(0, 3); wait_idle();
    expect_evt("R1 cnvst 2 cycles", 7'b0000100, 5, 0);
    pulse(1, 2); wait_idle();
    expect_evt("R1 comparator", 7'b0010000, 4, 0);
    pulse(2, 1); wait_idle();
    expect_evt("R1 missing clock", 7'b0100000, 4, 0);
    pulse(3, 1); wait_idle();
    expect_evt("R1 watchdog", 7'b1000000, 4, 0);
    pulse(4, 1); wait_idle();

    // Second request while in reset keeps the first cause.
    expect_evt("R6 cause held during reset", 7'b1000000, 5, 0);
    wdt_expire = 1'b1; tick(1); wdt_expire = 1'b0; tick(2);
    sw_strobe = 1'b1; tick(1); sw_strobe = 1'b0;
    wait_idle();

    expect_evt("R7 simultaneous cnvst and comparator", 7'b0000100, 4, 0);
    cnvst = 1'b1; cmp_trip = 1'b1; tick(1); cnvst = 1'b0; cmp_trip = 1'b0;
    wait_idle();

    src_en = 4'h0;
    for (int s = 1; s <= 4; s++) begin
      pulse(s, 2);
      tick(8);
      chk("R2 disabled source leaves reset low", 32'(sys_rst), 32'd0);
    end
    chk("R2 disabled source leaves cause", 32'(cause), 32'h04);
    src_en = 4'hF;

    expect_evt("R5 R8 R10 software power-on", 7'b0000001, TMO + HOLD, TMO);
    sw_por = 1'b1; tick(1); sw_por = 1'b0;
    wait_idle();

    tick(2);
    chk("R1 scoreboard drained", 32'(qf.size()), 32'd0);
    finish_run();
  end
endmodule